// File: doc/BRIEF.md
# Byte-Wide SONET Receive Framer with Section Parity Monitor

This block sits on the receive side of a line interface. It takes one byte of a SONET stream per clock and locks onto the frame by looking for the two-byte framing word. It then keeps that lock with hysteresis, and reports an out-of-frame flag and a slower loss-of-frame flag. Once the frame position is known, the block removes the frame-synchronous scrambling and checks the section parity byte. It also marks the start of every aligned frame.

The frame size is a parameter. The defaults give a single 9-row by 90-column frame of 810 bytes, and the block counts the byte position within that frame. Parity mismatches are summed, bit by bit, into a saturating counter. A one-cycle strobe copies the counter into a hold register and restarts the count, so no event is lost between two readings. An external loss-of-signal input forces the framer back into search.

Top module: `rx_framer`

## Requirements
- R1: Alignment is found when a byte equal to 0xF6 is immediately followed by a byte equal to 0x28. The 0xF6 byte is frame position 0, the 0x28 byte is position 1, and position 2 is the trace byte. The parity byte is position 90 (the first byte of the second row), and a frame is 810 bytes long.
- R2: After reset `oof_out` is 1. A search hit counts as one good framing pattern. `oof_out` falls only after a second good pattern at positions 0/1 of the next frame, so it is still 1 after the first aligned frame.
- R3: While in frame, `oof_out` rises after 4 consecutive frames whose positions 0/1 do not hold 0xF6,0x28. Three errored frames followed by a good one leave it at 0.
- R4: `lof_out` rises after `oof_out` has been 1 for 24 consecutive frame periods. It falls after 24 consecutive frame periods with `oof_out` at 0.
- R5: `los_in` high forces `oof_out` to 1 at the next clock and drops the current alignment candidate.
- R6: `data_out` is the input byte delayed by one clock. Positions 0, 1 and 2 pass unchanged. Every later byte is XORed with a keystream from the generator 1+x^6+x^7, which is a 7-bit state s, loaded with all ones at position 3. For each output bit, MSB first, the bit is s[6], then s shifts left with s[6]^s[5] entering bit 0.
- R7: `sof_out` is a one-clock pulse on the cycle that `data_out` carries the position-0 byte. It is produced only when the block was in frame as that byte arrived.
- R8: The even parity of all 810 received (still scrambled) bytes of one frame is compared with the descrambled position-90 byte of the next frame. Each differing bit adds one to the error count. This is done only while in frame and after one full frame since alignment.
- R9: The error count saturates at 2^CNT_W-1.
- R10: A high `cnt_latch` copies the error count into `err_snap` at that clock and restarts the count from zero. Errors found in the same clock go into the new count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_byte | input | 8 | Received line byte |
| los_in | input | 1 | External loss-of-signal |
| cnt_latch | input | 1 | Latch-and-clear strobe for the parity error count |
| data_out | output | 8 | Descrambled byte, one clock after input |
| sof_out | output | 1 | Frame-start pulse aligned with position-0 byte on `data_out` |
| oof_out | output | 1 | Out-of-frame flag |
| lof_out | output | 1 | Loss-of-frame flag |
| err_snap | output | CNT_W | Error count captured by the last strobe |

## Verification
`data_out` and `sof_out` change at the clock edge after the byte enters. The bench therefore compares each output byte at the falling edge of the following push, against the expectation it kept from the previous byte. `oof_out` moves at the edge that takes in the position-1 byte, `lof_out` moves on a frame-end edge, and `err_snap` moves at the edge of the strobe. The bench reads these only after a frame or a strobe has fully passed. The loss-of-frame limit of 24 frame periods is checked with a window of frames on either side, because the frame tick runs on the block's own position count.

// File: rtl/rx_framer.sv
module rx_framer #(
  parameter int ROWS       = 9,
  parameter int COLS       = 90,
  parameter int OH_COLS    = 3,
  parameter logic [7:0] A1_VAL = 8'hF6,
  parameter logic [7:0] A2_VAL = 8'h28,
  parameter int OOF_SET    = 4,
  parameter int OOF_CLR    = 2,
  parameter int LOF_FRAMES = 24,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       line_byte,
  input  logic             los_in,
  input  logic             cnt_latch,
  output logic [7:0]       data_out,
  output logic             sof_out,
  output logic             oof_out,
  output logic             lof_out,
  output logic [CNT_W-1:0] err_snap
);
  localparam int FRAME = ROWS * COLS;
  localparam int POS_W = $clog2(FRAME);
  localparam int HW    = $clog2(OOF_SET + OOF_CLR);
  localparam int FW    = $clog2(LOF_FRAMES + 1);
  localparam logic [POS_W-1:0] P_A2   = POS_W'(1);
  localparam logic [POS_W-1:0] P_J0   = POS_W'(2);
  localparam logic [POS_W-1:0] P_SCR  = POS_W'(OH_COLS);
  localparam logic [POS_W-1:0] P_B1   = POS_W'(COLS);
  localparam logic [POS_W-1:0] P_LAST = POS_W'(FRAME - 1);

  function automatic logic [14:0] scr_step(input logic [6:0] s);
    logic [7:0] k;
    logic [6:0] t;
    t = s;
    for (int i = 7; i >= 0; i--) begin
      k[i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    return {t, k};
  endfunction

  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + 4'(v[i]);
    return n;
  endfunction

  logic [POS_W-1:0] pos;
  logic [7:0]       last_byte;
  logic             oof, cand, lof;
  logic [HW-1:0]    gcnt, bcnt;
  logic [FW-1:0]    fcnt;
  logic [6:0]       scr, scr_nx;
  logic [7:0]       ks, plain, bip, bip_prev;
  logic             prev_ok;
  logic [CNT_W-1:0] cnt;

  wire pat_ok   = (last_byte == A1_VAL) && (line_byte == A2_VAL);
  wire at_chk   = (pos == P_A2);
  wire hunt_hit = oof && !cand && pat_ok && !los_in;
  wire tick     = (pos == P_LAST);

  wire [6:0] scr_seed = (pos == P_SCR) ? 7'h7F : scr;
  assign {scr_nx, ks} = scr_step(scr_seed);
  assign plain = (pos >= P_SCR) ? (line_byte ^ ks) : line_byte;

  wire              b1_chk   = (pos == P_B1) && !oof && prev_ok;
  wire [3:0]        nerr     = b1_chk ? ones8(bip_prev ^ plain) : 4'd0;
  wire [CNT_W-1:0]  cnt_base = cnt_latch ? '0 : cnt;
  wire [CNT_W:0]    sum      = {1'b0, cnt_base} + (CNT_W+1)'(nerr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      last_byte <= '0;
      scr       <= 7'h7F;
    end else begin
      last_byte <= line_byte;
      scr       <= scr_nx;
      if (hunt_hit)  pos <= P_J0;
      else if (tick) pos <= '0;
      else           pos <= pos + POS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || los_in) begin
      oof  <= 1'b1;
      cand <= 1'b0;
      gcnt <= '0;
      bcnt <= '0;
    end else if (oof) begin
      if (!cand) begin
        if (pat_ok) begin
          cand <= 1'b1;
          gcnt <= HW'(1);
        end
      end else if (at_chk) begin
        if (!pat_ok) begin
          cand <= 1'b0;
          gcnt <= '0;
        end else if (gcnt == HW'(OOF_CLR - 1)) begin
          oof  <= 1'b0;
          cand <= 1'b0;
          gcnt <= '0;
          bcnt <= '0;
        end else begin
          gcnt <= gcnt + HW'(1);
        end
      end
    end else if (at_chk) begin
      if (pat_ok) bcnt <= '0;
      else if (bcnt == HW'(OOF_SET - 1)) begin
        oof  <= 1'b1;
        bcnt <= '0;
      end else bcnt <= bcnt + HW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lof  <= 1'b0;
      fcnt <= '0;
    end else if (lof != oof) begin
      if (tick) begin
        if (fcnt == FW'(LOF_FRAMES - 1)) begin
          lof  <= ~lof;
          fcnt <= '0;
        end else fcnt <= fcnt + FW'(1);
      end
    end else begin
      fcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bip      <= '0;
      bip_prev <= '0;
      prev_ok  <= 1'b0;
    end else if (hunt_hit) begin
      bip     <= last_byte ^ line_byte;
      prev_ok <= 1'b0;
    end else begin
      if (tick) begin
        bip      <= '0;
        bip_prev <= bip ^ line_byte;
      end else begin
        bip <= bip ^ line_byte;
      end
      if (los_in)    prev_ok <= 1'b0;
      else if (tick) prev_ok <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      err_snap <= '0;
    end else begin
      if (cnt_latch) err_snap <= cnt;
      cnt <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_out <= '0;
      sof_out  <= 1'b0;
    end else begin
      data_out <= plain;
      sof_out  <= (pos == '0) && !oof;
    end
  end

  assign oof_out = oof;
  assign lof_out = lof;
endmodule

// File: rtl/rx_framer_chk.sv
module rx_framer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             los_in,
  input logic             cnt_latch,
  input logic             sof_out,
  input logic             oof_out,
  input logic             lof_out,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] err_snap
);
  assert_los_forces_oof_R5: assert property (@(posedge clk) disable iff (!rst_n)
    los_in |=> oof_out);

  assert_oof_clear_not_in_los_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oof_out) |-> !$past(los_in));

  assert_lof_needs_oof_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lof_out) |-> $past(oof_out));

  assert_lof_clear_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lof_out) |-> !$past(oof_out));

  assert_sof_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_out |-> !$past(oof_out));

  assert_sof_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sof_out |=> !sof_out);

  assert_count_saturates_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((&cnt) && !cnt_latch) |=> (&cnt));

  assert_latch_copies_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_latch |=> (err_snap == $past(cnt)));
endmodule

bind rx_framer rx_framer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .los_in(los_in), .cnt_latch(cnt_latch),
  .sof_out(sof_out), .oof_out(oof_out), .lof_out(lof_out),
  .cnt(cnt), .err_snap(err_snap)
);

// File: tb/rx_framer_bench.sv
module rx_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 810;
  localparam int CW = 6;

  logic clk = 0, rst_n = 0, los_in = 0, cnt_latch = 0;
  logic [7:0] line_byte = 0;
  logic [7:0] data_out;
  logic sof_out, oof_out, lof_out;
  logic [CW-1:0] err_snap;

  int total = 0, bad = 0;
  logic [7:0] fr_raw [0:FRAME-1];
  logic [7:0] fr_plain [0:FRAME-1];
  logic [7:0] par_prev = 0;
  logic pend_chk = 0, pend_s = 0;
  logic [7:0] pend_d = 0;
  int bad_d = 0, bad_s = 0;
  int exp_cnt = 0, exp_snap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_framer #(.CNT_W(CW)) u_rx_framer (
    .clk(clk), .rst_n(rst_n), .line_byte(line_byte), .los_in(los_in),
    .cnt_latch(cnt_latch), .data_out(data_out), .sof_out(sof_out),
    .oof_out(oof_out), .lof_out(lof_out), .err_snap(err_snap)
  );

  function automatic logic [14:0] ks_next(input logic [6:0] s);
    logic [7:0] k;
    logic [6:0] t;
    t = s;
    for (int i = 7; i >= 0; i--) begin
      k[i] = t[6];
      t = {t[5:0], t[6] ^ t[5]};
    end
    return {t, k};
  endfunction

  function automatic int ones(input logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  task automatic check(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic [7:0] b, input logic clr, input logic chk,
                      input logic [7:0] ed, input logic es);
    @(negedge clk);
    if (pend_chk) begin
      if (data_out !== pend_d) bad_d++;
      if (sof_out !== pend_s) bad_s++;
    end
    line_byte = b;
    cnt_latch = clr;
    pend_chk = chk;
    pend_d = ed;
    pend_s = es;
  endtask

  function automatic logic [7:0] rand_not_a1();
    logic [7:0] v = 8'($urandom);
    if (v == 8'hF6) v = 8'h00;
    return v;
  endfunction

  task automatic build_frame(input logic [7:0] mask, input logic bad_a1);
    logic [6:0] s = 7'h7F;
    logic [14:0] st;
    logic [7:0] acc = 0;
    logic [7:0] prev = 0;
    for (int p = 0; p < FRAME; p++) begin
      if (p < 3) begin
        fr_plain[p] = (p == 0) ? (bad_a1 ? 8'hF7 : 8'hF6) : (p == 1) ? 8'h28 : 8'h01;
        fr_raw[p] = fr_plain[p];
      end else begin
        st = ks_next((p == 3) ? 7'h7F : s);
        s = st[14:8];
        if (p == 90) fr_plain[p] = par_prev ^ mask;
        else begin
          fr_plain[p] = 8'($urandom);
          if (((fr_plain[p] ^ st[7:0]) == 8'hF6) ||
              (prev == 8'hF6 && (fr_plain[p] ^ st[7:0]) == 8'h28))
            fr_plain[p] ^= 8'h01;
        end
        fr_raw[p] = fr_plain[p] ^ st[7:0];
      end
      prev = fr_raw[p];
      acc ^= fr_raw[p];
    end
    par_prev = acc;
  endtask

  // frame with optional B1 error mask (R8), corrupted A1 (R3), strobe at position 5 (R10)
  task automatic send_frame(input logic [7:0] mask, input logic bad_a1, input logic clr,
                            input logic chk, input logic sofv);
    build_frame(mask, bad_a1);
    bad_d = 0;
    bad_s = 0;
    if (clr) begin
      exp_snap = exp_cnt;
      exp_cnt = 0;
    end
    exp_cnt += ones(mask);
    if (exp_cnt > (1 << CW) - 1) exp_cnt = (1 << CW) - 1;
    for (int p = 0; p < FRAME; p++)
      push(fr_raw[p], clr && (p == 5), chk, fr_plain[p], (p == 0) ? sofv : 1'b0);
    if (chk) begin
      check("R6 descrambled data", bad_d, 0);
      check("R7 frame start pulse", bad_s, 0);
    end
    if (clr) check("R10 latched error count", int'(err_snap), exp_snap);
  endtask

  task automatic send_junk(input int n);
    for (int i = 0; i < n; i++) push(rand_not_a1(), 1'b0, 1'b0, 8'h00, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R2 reset oof", int'(oof_out), 1);
    check("R4 reset lof", int'(lof_out), 0);
    check("R7 reset sof", int'(sof_out), 0);
    check("R10 reset snap", int'(err_snap), 0);

    send_junk(37);
    send_frame(8'h00, 0, 0, 0, 0);
    check("R2 one good pattern keeps oof", int'(oof_out), 1);
    send_frame(8'h00, 0, 0, 1, 0);
    check("R1 R2 aligned after second pattern", int'(oof_out), 0);
    for (int f = 2; f < 6; f++) send_frame(8'h00, 0, 0, 1, 1);
    send_frame(8'h81, 0, 0, 1, 1);
    send_frame(8'h00, 0, 1, 1, 1);
    send_frame(8'hFF, 0, 0, 1, 1);
    send_frame(8'h00, 0, 1, 1, 1);
    check("R8 parity bit errors counted", int'(err_snap), 8);
    for (int f = 0; f < 9; f++) send_frame(8'hFF, 0, 0, 1, 1);
    send_frame(8'h00, 0, 1, 1, 1);
    check("R9 saturated count", int'(err_snap), 63);
    send_frame(8'h3C, 0, 1, 1, 1);
    check("R10 count restarted", int'(err_snap), 0);
    send_frame(8'h00, 0, 1, 1, 1);
    check("R8 R10 new count after strobe", int'(err_snap), 4);

    for (int f = 0; f < 3; f++) send_frame(8'h00, 1, 0, 1, 1);
    send_frame(8'h00, 0, 0, 1, 1);
    check("R3 three bad patterns keep alignment", int'(oof_out), 0);
    for (int f = 0; f < 3; f++) send_frame(8'h00, 1, 0, 1, 1);
    check("R3 still in frame after three", int'(oof_out), 0);
    send_frame(8'h00, 1, 0, 1, 1);
    check("R3 fourth bad pattern sets oof", int'(oof_out), 1);
    send_frame(8'h00, 0, 0, 1, 0);
    check("R2 relock needs second pattern", int'(oof_out), 1);
    send_frame(8'h00, 0, 0, 1, 0);
    check("R2 relocked", int'(oof_out), 0);
    send_frame(8'h00, 0, 0, 1, 1);

    @(negedge clk);
    los_in = 1;
    line_byte = rand_not_a1();
    pend_chk = 0;
    @(negedge clk);
    check("R5 los forces oof", int'(oof_out), 1);
    send_junk(22 * FRAME);
    check("R4 lof not yet", int'(lof_out), 0);
    send_junk(4 * FRAME);
    check("R4 lof declared", int'(lof_out), 1);
    los_in = 0;
    send_frame(8'h00, 0, 0, 0, 0);
    send_frame(8'h00, 0, 0, 1, 0);
    check("R2 aligned after los", int'(oof_out), 0);
    for (int f = 0; f < 19; f++) send_frame(8'h00, 0, 0, 1, 1);
    check("R4 lof held while recovering", int'(lof_out), 1);
    for (int f = 0; f < 7; f++) send_frame(8'h00, 0, 0, 1, 1);
    send_frame(8'h00, 0, 1, 1, 1);
    check("R4 lof cleared", int'(lof_out), 0);
    check("R8 no parity errors on clean frames", int'(err_snap), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule